// File: doc/BRIEF.md
# Strided Masked Vector Address Generator

This block turns one vector-load descriptor into a stream of per-element memory addresses, each tagged with the destination slot in a 64-slot register file. The descriptor holds a base effective address, a signed stride counted in operand-size units, a slot window (low and high slot index), the operand size, an addressing-width flag, an optional indirect flag, and an optional 64-bit slot mask supplied as two 32-bit words together with the index of the register pair that holds it.

When indirect mode is requested, the block first reads a pointer from memory at the effective address, over a simple request/response port. The fetched value then serves as the vector's base. The slot window sets only the element count. The first memory element always lands in the low slot, so a shorter window trims the tail of the memory vector. Masked-off slots emit nothing, but their memory positions are still stepped over. Elements leave one per cycle under a valid/ready handshake, and a one-cycle done pulse closes the run.

Top module: `vec_agen`

## Requirements
- R1: After reset, busy_o, elem_valid_o, done_o, err_o and ptr_req_o are all low.
- R2: Element k (k counted from 0 in memory order) has address base + stride*k*B. The stride is a 10-bit two's-complement value. B is 1, 2, 4 or 8 for size_i values 0, 1, 2 and 3.
- R3: A stride of zero gives every element the base address (scalar broadcast).
- R4: A run covers slot_hi_i - slot_lo_i + 1 memory elements. Element k is written to slot slot_lo_i + k, and element 0 is always at the base.
- R5: With mask_en_i set, slot s is enabled by bit 63-s of the concatenation {mask_w0_i, mask_w1_i}, so the MSB of mask_w0_i controls slot 0 and the LSB of mask_w1_i controls slot 63. A disabled slot emits no element, but the address stream still advances past its position.
- R6: A start is refused in two cases: mask_en_i is set and mask_pair_i is odd (only 0, 2, 4 and 6 are legal), or slot_hi_i < slot_lo_i. A refused start raises err_o for exactly one cycle, produces no element and leaves busy_o low.
- R7: With indirect_i set, ptr_req_o stays high with ptr_addr_o equal to the effective address until ptr_rvalid_i arrives. The returned ptr_rdata_i then becomes the base.
- R8: With addr64_i clear, the effective address, the fetched pointer and every element address are taken modulo 2^32, with the upper 32 bits zero. With addr64_i set, they are taken modulo 2^64.
- R9: While elem_valid_o is high and elem_ready_i is low, the element holds with elem_addr_o and elem_slot_o stable.
- R10: done_o pulses for one cycle after the last element, and busy_o drops the cycle after that. A start_i and any change to the descriptor inputs while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Descriptor strobe, sampled while idle |
| ea_i | input | 64 | Effective address |
| indirect_i | input | 1 | Fetch the base pointer at ea_i |
| addr64_i | input | 1 | 64-bit addressing when high, 32-bit when low |
| stride_i | input | 10 | Signed stride in operand units |
| size_i | input | 2 | Operand size code (bytes = 1 << size_i) |
| slot_lo_i | input | 6 | First destination slot |
| slot_hi_i | input | 6 | Last destination slot |
| mask_en_i | input | 1 | Apply the slot mask |
| mask_pair_i | input | 3 | Index of the mask register pair |
| mask_w0_i | input | 32 | First mask word (slots 0..31, MSB first) |
| mask_w1_i | input | 32 | Second mask word (slots 32..63) |
| ptr_req_o | output | 1 | Pointer read request |
| ptr_addr_o | output | 64 | Pointer read address |
| ptr_rvalid_i | input | 1 | Pointer read response valid |
| ptr_rdata_i | input | 64 | Pointer read data |
| elem_valid_o | output | 1 | Element available |
| elem_ready_i | input | 1 | Downstream accepts the element |
| elem_addr_o | output | 64 | Element memory address |
| elem_slot_o | output | 6 | Element destination slot |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | One-cycle refused-descriptor pulse |

## Verification
The bench builds the block with its default parameters: 64-bit addresses, a 32-bit narrow width, 64 slots and a 10-bit stride. This makes the full two-word mask reachable, including slot 63 controlled by the last bit of the second word. It also reaches the wrap of element addresses at 2^32 in narrow mode, and the stride extremes of -512 and +511 combined with 8-byte operands. Random descriptors, random ready throttling and random pointer latency run alongside directed cases for broadcast, tail trimming, odd pair indices, inverted windows and starts issued while busy.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } vag_state_e;
endpackage

// File: rtl/vag_cfg_check.sv
module vag_cfg_check #(
  parameter int SLOT_W = 6,
  parameter int PAIR_W = 3
) (
  input  logic              mask_en_i,
  input  logic [PAIR_W-1:0] mask_pair_i,
  input  logic [SLOT_W-1:0] slot_lo_i,
  input  logic [SLOT_W-1:0] slot_hi_i,
  output logic              ok_o
);
  // pair index must be even; window must not be inverted
  always_comb ok_o = (!mask_en_i || !mask_pair_i[0]) && (slot_hi_i >= slot_lo_i);
endmodule

// File: rtl/vag_mask_sel.sv
module vag_mask_sel #(
  parameter int SLOTS  = 64,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOTS/2-1:0] w0_i,
  input  logic [SLOTS/2-1:0] w1_i,
  input  logic               en_i,
  input  logic [SLOT_W-1:0]  slot_i,
  output logic               bit_o
);
  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(SLOTS - 1);
  logic [SLOTS-1:0]  vec;
  logic [SLOT_W-1:0] pos;

  always_comb begin
    vec   = {w0_i, w1_i};
    pos   = TOP - slot_i;
    bit_o = !en_i || vec[pos];
  end
endmodule

// File: rtl/vag_addr_acc.sv
module vag_addr_acc #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter int STRIDE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   load_val_i,
  input  logic                wide_i,
  input  logic                step_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [1:0]          size_i,
  output logic [ADDR_W-1:0]   addr_o
);
  localparam int EXT_W = ADDR_W - STRIDE_W;

  logic [ADDR_W-1:0] acc_q, step_w, sum_w, nxt_w;

  function automatic logic [ADDR_W-1:0] fit(input logic [ADDR_W-1:0] v, input logic wide);
    fit = wide ? v : {{(ADDR_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
  endfunction

  always_comb begin
    step_w = {{EXT_W{stride_i[STRIDE_W-1]}}, stride_i} << size_i;
    sum_w  = acc_q + step_w;
    nxt_w  = load_i ? fit(load_val_i, wide_i) : fit(sum_w, wide_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (load_i || step_i)  acc_q <= nxt_w;
  end

  assign addr_o = acc_q;

  p_scalar_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && stride_i == '0) |=> $stable(acc_q));

  p_narrow_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((load_i || step_i) && !wide_i) |=> (acc_q[ADDR_W-1:NARROW_W] == '0));
endmodule

// File: rtl/vag_ctrl.sv
module vag_ctrl
  import vag_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cfg_ok_i,
  input  logic              indirect_i,
  input  logic              ptr_rvalid_i,
  input  logic [SLOT_W-1:0] len_m1_i,
  input  logic              mask_bit_i,
  input  logic              elem_ready_i,
  output logic              accept_o,
  output logic              load_o,
  output logic              ptr_req_o,
  output logic              step_o,
  output logic [SLOT_W-1:0] idx_o,
  output logic              elem_valid_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o
);
  vag_state_e        state_q, state_d;
  logic [SLOT_W-1:0] idx_q;
  logic              err_q, last_w;

  always_comb begin
    accept_o     = (state_q == ST_IDLE) && start_i && cfg_ok_i;
    ptr_req_o    = (state_q == ST_FETCH);
    load_o       = (accept_o && !indirect_i) || (ptr_req_o && ptr_rvalid_i);
    elem_valid_o = (state_q == ST_RUN) && mask_bit_i;
    step_o       = (state_q == ST_RUN) && (!mask_bit_i || elem_ready_i);
    last_w       = (idx_q == len_m1_i);
    done_o       = (state_q == ST_DONE);
    busy_o       = (state_q != ST_IDLE);

    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = indirect_i ? ST_FETCH : ST_RUN;
      ST_FETCH: if (ptr_rvalid_i) state_d = ST_RUN;
      ST_RUN:   if (step_o && last_w) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= (state_q == ST_IDLE) && start_i && !cfg_ok_i;
      if (accept_o)                idx_q <= '0;
      else if (step_o && !last_w)  idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o = idx_q;
  assign err_o = err_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_valid_o && !elem_ready_i) |=> (elem_valid_o && $stable(idx_q)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_err_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !elem_valid_o));

  p_req_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_req_o && !ptr_rvalid_i) |=> ptr_req_o);
endmodule

// File: rtl/vec_agen.sv
module vec_agen #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter int SLOTS    = 64,
  parameter int STRIDE_W = 10,
  parameter int PAIR_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [ADDR_W-1:0]         ea_i,
  input  logic                      indirect_i,
  input  logic                      addr64_i,
  input  logic [STRIDE_W-1:0]       stride_i,
  input  logic [1:0]                size_i,
  input  logic [$clog2(SLOTS)-1:0]  slot_lo_i,
  input  logic [$clog2(SLOTS)-1:0]  slot_hi_i,
  input  logic                      mask_en_i,
  input  logic [PAIR_W-1:0]         mask_pair_i,
  input  logic [SLOTS/2-1:0]        mask_w0_i,
  input  logic [SLOTS/2-1:0]        mask_w1_i,
  output logic                      ptr_req_o,
  output logic [ADDR_W-1:0]         ptr_addr_o,
  input  logic                      ptr_rvalid_i,
  input  logic [ADDR_W-1:0]         ptr_rdata_i,
  output logic                      elem_valid_o,
  input  logic                      elem_ready_i,
  output logic [ADDR_W-1:0]         elem_addr_o,
  output logic [$clog2(SLOTS)-1:0]  elem_slot_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int HALF   = SLOTS / 2;

  logic                cfg_ok, accept, load, step, mask_bit, wide_sel;
  logic [SLOT_W-1:0]   idx, len_m1, slot_w;
  logic [ADDR_W-1:0]   load_val;

  logic [ADDR_W-1:0]   ea_q;
  logic                wide_q, men_q;
  logic [STRIDE_W-1:0] stride_q;
  logic [1:0]          size_q;
  logic [SLOT_W-1:0]   lo_q, hi_q;
  logic [HALF-1:0]     w0_q, w1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q <= '0; wide_q <= 1'b0; men_q <= 1'b0; stride_q <= '0; size_q <= '0;
      lo_q <= '0; hi_q <= '0; w0_q <= '0; w1_q <= '0;
    end else if (accept) begin
      ea_q     <= addr64_i ? ea_i : {{(ADDR_W-NARROW_W){1'b0}}, ea_i[NARROW_W-1:0]};
      wide_q   <= addr64_i;
      men_q    <= mask_en_i;
      stride_q <= stride_i;
      size_q   <= size_i;
      lo_q     <= slot_lo_i;
      hi_q     <= slot_hi_i;
      w0_q     <= mask_w0_i;
      w1_q     <= mask_w1_i;
    end
  end

  always_comb begin
    len_m1   = hi_q - lo_q;
    slot_w   = lo_q + idx;
    wide_sel = accept ? addr64_i : wide_q;
    load_val = ptr_req_o ? ptr_rdata_i : ea_i;
  end

  vag_cfg_check #(.SLOT_W(SLOT_W), .PAIR_W(PAIR_W)) u_cfg (
    .mask_en_i(mask_en_i), .mask_pair_i(mask_pair_i),
    .slot_lo_i(slot_lo_i), .slot_hi_i(slot_hi_i), .ok_o(cfg_ok)
  );

  vag_mask_sel #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_mask (
    .w0_i(w0_q), .w1_i(w1_q), .en_i(men_q), .slot_i(slot_w), .bit_o(mask_bit)
  );

  vag_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cfg_ok_i(cfg_ok),
    .indirect_i(indirect_i), .ptr_rvalid_i(ptr_rvalid_i), .len_m1_i(len_m1),
    .mask_bit_i(mask_bit), .elem_ready_i(elem_ready_i), .accept_o(accept),
    .load_o(load), .ptr_req_o(ptr_req_o), .step_o(step), .idx_o(idx),
    .elem_valid_o(elem_valid_o), .done_o(done_o), .err_o(err_o), .busy_o(busy_o)
  );

  vag_addr_acc #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .STRIDE_W(STRIDE_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(load_val),
    .wide_i(wide_sel), .step_i(step), .stride_i(stride_q), .size_i(size_q),
    .addr_o(elem_addr_o)
  );

  assign ptr_addr_o  = ea_q;
  assign elem_slot_o = slot_w;

  p_slot_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_valid_o |-> (elem_slot_o >= lo_q && elem_slot_o <= hi_q));

  p_stall_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_valid_o && !elem_ready_i) |=> ($stable(elem_addr_o) && $stable(elem_slot_o)));

  p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> ($stable(lo_q) && $stable(stride_q) && $stable(w0_q)));
endmodule

// File: tb/sim_vec_agen.sv
module sim_vec_agen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, ind = 0, a64 = 0, men = 0, rvalid = 0, ready = 0;
  logic [63:0] ea = '0, rdata = '0;
  logic [9:0]  stride = '0;
  logic [1:0]  size = '0;
  logic [5:0]  lo = '0, hi = '0;
  logic [2:0]  pair = '0;
  logic [31:0] w0 = '0, w1 = '0;
  logic        req, valid, busy, done, err;
  logic [63:0] paddr, eaddr;
  logic [5:0]  eslot;

  int n_chk = 0, n_bad = 0;
  logic [63:0] exp_addr [64];
  logic [5:0]  exp_slot [64];
  int          exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_agen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ea_i(ea), .indirect_i(ind),
    .addr64_i(a64), .stride_i(stride), .size_i(size), .slot_lo_i(lo), .slot_hi_i(hi),
    .mask_en_i(men), .mask_pair_i(pair), .mask_w0_i(w0), .mask_w1_i(w1),
    .ptr_req_o(req), .ptr_addr_o(paddr), .ptr_rvalid_i(rvalid), .ptr_rdata_i(rdata),
    .elem_valid_o(valid), .elem_ready_i(ready), .elem_addr_o(eaddr), .elem_slot_o(eslot),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] narrow(input logic [63:0] v, input logic wide);
    return wide ? v : {32'h0, v[31:0]};
  endfunction

  task automatic build_expect();
    logic [63:0] base, sx, bytes, a;
    logic [63:0] mv;
    exp_n = 0;
    base  = narrow(ind ? rdata : ea, a64);
    sx    = {{54{stride[9]}}, stride};
    bytes = 64'd1 << size;
    mv    = {w0, w1};
    for (int k = 0; k <= int'(hi) - int'(lo); k++) begin
      logic [5:0] s;
      s = lo + 6'(k);
      a = narrow(base + sx * 64'(k) * bytes, a64);
      if (!men || mv[63 - s]) begin
        exp_addr[exp_n] = a;
        exp_slot[exp_n] = s;
        exp_n++;
      end
    end
  endtask

  task automatic run_case(input string tag, input bit junk);
    bit          bad, stall, fetched;
    logic [63:0] st_addr;
    logic [5:0]  st_slot;
    int          got;
    bad = (men && pair[0]) || (hi < lo);
    if (!bad) build_expect();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    if (bad) begin
      chk(err === 1'b1 && busy === 1'b0, "R6 err pulse", {62'h0, err, busy}, 64'h2);
      @(negedge clk);
      chk(err === 1'b0 && busy === 1'b0 && valid === 1'b0, "R6 no run", {61'h0, err, busy, valid}, 64'h0);
      return;
    end
    chk(busy === 1'b1 && err === 1'b0, {tag, " R10 busy"}, {62'h0, busy, err}, 64'h2);
    if (junk) begin
      start = 1; ea = ~ea; lo = 6'd0; hi = 6'd63; stride = 10'd1; w0 = ~w0; men = 0;
    end
    stall = 0; fetched = 0; got = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc == 1) start = 0;
      if (req) begin
        if (!fetched) chk(paddr === narrow(ea_saved, a64_saved), "R7 ptr addr", paddr, narrow(ea_saved, a64_saved));
        fetched = 1;
        rvalid = ($urandom % 3 == 0);
      end else rvalid = 0;
      if (stall) chk(valid === 1'b1 && eaddr === st_addr && eslot === st_slot, "R9 hold", eaddr, st_addr);
      stall = 0;
      ready = ($urandom % 4 != 0);
      #1;
      if (done) begin
        chk(got == exp_n, {tag, " R4 count"}, 64'(got), 64'(exp_n));
        break;
      end
      if (valid) begin
        if (got >= exp_n) chk(0, {tag, " R5 extra elem"}, eaddr, 64'h0);
        else if (ready) begin
          chk(eaddr === exp_addr[got], {tag, " R2 addr"}, eaddr, exp_addr[got]);
          chk(eslot === exp_slot[got], {tag, " R4 slot"}, 64'(eslot), 64'(exp_slot[got]));
          got++;
        end else begin
          stall = 1; st_addr = eaddr; st_slot = eslot;
        end
      end
      @(negedge clk);
      if (cyc == 2999) chk(0, "watchdog", 64'(cyc), 64'h0);
    end
    rvalid = 0;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " R10 end"}, {62'h0, done, busy}, 64'h0);
  endtask

  logic [63:0] ea_saved;
  logic        a64_saved;
  always @(posedge clk) if (start && !busy) begin ea_saved <= ea; a64_saved <= a64; end

  task automatic setd(input logic [63:0] e, input bit i, input bit w, input logic [9:0] st,
                      input logic [1:0] sz, input logic [5:0] l, input logic [5:0] h,
                      input bit me, input logic [2:0] p, input logic [31:0] m0,
                      input logic [31:0] m1, input logic [63:0] rd);
    ea = e; ind = i; a64 = w; stride = st; size = sz; lo = l; hi = h;
    men = me; pair = p; w0 = m0; w1 = m1; rdata = rd;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy === 0 && valid === 0 && done === 0 && err === 0 && req === 0, "R1 reset",
        {59'h0, busy, valid, done, err, req}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && valid === 0 && req === 0, "R1 idle", {61'h0, busy, valid, req}, 64'h0);

    setd(64'h1000, 0, 0, 10'd1, 2'd2, 6'd0, 6'd63, 0, 3'd0, 0, 0, 0);
    run_case("R2 contiguous", 0);
    setd(64'h2000_0040, 0, 0, 10'd0, 2'd3, 6'd5, 6'd20, 0, 3'd1, 0, 0, 0);
    run_case("R3 scalar", 0);
    setd(64'h0000_8000, 0, 0, 10'h200, 2'd3, 6'd0, 6'd9, 0, 3'd0, 0, 0, 0);
    run_case("R2 stride -512", 0);
    setd(64'h0000_0100, 0, 0, 10'd511, 2'd3, 6'd60, 6'd63, 0, 3'd0, 0, 0, 0);
    run_case("R2 stride 511", 0);
    setd(64'h3000, 0, 0, 10'd3, 2'd1, 6'd10, 6'd40, 1, 3'd4, 32'hA5F0_0F5A, 32'h1234_5678, 0);
    run_case("R5 mask window", 0);
    setd(64'h400, 0, 0, 10'd1, 2'd0, 6'd63, 6'd63, 1, 3'd6, 32'h0, 32'h1, 0);
    run_case("R5 slot63 lsb", 0);
    setd(64'h400, 0, 0, 10'd1, 2'd0, 6'd0, 6'd0, 1, 3'd2, 32'h8000_0000, 32'h0, 0);
    run_case("R5 slot0 msb", 0);
    setd(64'h400, 0, 0, 10'd1, 2'd0, 6'd0, 6'd31, 1, 3'd0, 32'h0, 32'hFFFF_FFFF, 0);
    run_case("R5 all masked", 0);
    setd(64'hDEAD_0000_FFFF_FFF0, 0, 0, 10'd1, 2'd3, 6'd0, 6'd7, 0, 3'd0, 0, 0, 0);
    run_case("R8 wrap32", 0);
    setd(64'h0000_0001_FFFF_FFF0, 0, 1, 10'd1, 2'd3, 6'd0, 6'd7, 0, 3'd0, 0, 0, 0);
    run_case("R8 wide", 0);
    setd(64'h5555_0000_0000_0800, 1, 0, 10'd2, 2'd2, 6'd0, 6'd15, 0, 3'd0, 0, 0, 64'hFFFF_0000_0004_0000);
    run_case("R7 indirect32", 0);
    setd(64'h0000_0000_0000_0800, 1, 1, 10'h3FF, 2'd1, 6'd4, 6'd12, 0, 3'd0, 0, 0, 64'h0000_0100_0000_0000);
    run_case("R7 indirect64", 0);
    setd(64'h9000, 0, 0, 10'd1, 2'd2, 6'd0, 6'd7, 1, 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_case("R6 odd pair", 0);
    setd(64'h9000, 0, 0, 10'd1, 2'd2, 6'd9, 6'd8, 0, 3'd0, 0, 0, 0);
    run_case("R6 inverted", 0);
    setd(64'h9000, 0, 0, 10'd1, 2'd2, 6'd0, 6'd7, 0, 3'd5, 0, 0, 0);
    run_case("R6 pair unused", 0);
    setd(64'hA000, 0, 0, 10'd4, 2'd1, 6'd2, 6'd12, 1, 3'd2, 32'h3FF0_0000, 32'h0, 0);
    run_case("R10 start busy", 1);

    for (int i = 0; i < 60; i++) begin
      logic [5:0] l, h;
      l = 6'($urandom % 64);
      h = 6'($urandom % 64);
      if (h < l && ($urandom % 4 != 0)) begin logic [5:0] t; t = l; l = h; h = t; end
      setd({$urandom, $urandom}, 1'($urandom % 3 == 0), 1'($urandom), 10'($urandom),
           2'($urandom), l, h, 1'($urandom), 3'($urandom % 8), $urandom, $urandom,
           {$urandom, $urandom});
      run_case("R2 random", 1'($urandom % 5 == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule